// File: doc/BRIEF.md
# Banked Sequential Line Store

This block holds one video line of wide words and hands it back, word for word and in arrival order, exactly one line later. It is meant for line-delay duties in a pixel pipeline: every accepted input word displaces the word that arrived one full line earlier, and that older word appears on the output on the following cycle.

Storage is split into three banks. A phase ring deals incoming words to the banks in turn, so word k of a line lands in bank k mod 3, and each bank is touched on only one accepted word in three. This lets three slow banks keep pace with a fast stream. Inside a bank, no address is ever formed. A one-hot token circulates through a ring of flip-flops, and the set bit directly enables one storage row. An output stage re-serialises the three bank read registers in the original order. A line-start strobe moves every token and the phase ring back to the origin, so the word presented with it becomes word 0 of the line.

Top module: `seq_line_store`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is 0.
- R2: Each accepted word (a clock edge with `in_valid`=1) is stored, and the word previously held in the same position is read first. With the default sizes, the output word for the n-th accepted word since a line start is the word accepted 480 positions earlier in line order.
- R3: `out_valid` stays 0 until 480 words have been accepted since reset. The 481st accepted word is the first to produce a valid output.
- R4: Once filled, every accepted word produces `out_valid`=1 on the cycle after its acceptance edge, with the displaced word on `out_data`. A cycle with `in_valid`=0 gives `out_valid`=0 on the next cycle.
- R5: Cycles with `in_valid`=0 and `line_start`=0 leave the stored words and the slot and phase positions unchanged. Idle gaps of any length do not alter the output order.
- R6: `line_start`=1 sets the line position to 0 (bank 0, slot 0). If `in_valid` is also 1 on that edge, that word is stored at position 0. Otherwise the next accepted word is stored at position 0.
- R7: `line_start` erases neither the stored words nor the filled state. A word accepted after a mid-line strobe returns the word stored at the matching position of an earlier line.
- R8: Position p of a line maps to bank p mod 3 and slot p div 3. The three banks are used in the cyclic order 0,1,2, and each bank's slot token and the phase token are always exactly one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_start | input | 1 | Sets the line position back to 0 |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | 65 | Input word |
| out_valid | output | 1 | Output word present this cycle |
| out_data | output | 65 | Word displaced one line earlier |

## Verification
The hardest case to reach from the ports is a line-start strobe that arrives partway through a line, once the store has already been filled. At that point the bank tokens sit at different slots, and all of them must snap back together while the stored data survives. The stimulus first fills the store with irregular idle gaps. It then runs a clean second line, and then strobes line start after a count of words that is not a multiple of three, both alone and together with a valid word. A behavioural line-position model in the bench predicts every output word across these jumps.

// File: rtl/seq_line_pkg.sv
package seq_line_pkg;
   localparam int unsigned SLS_WORD_W = 65;
   localparam int unsigned SLS_BANKS  = 3;
   localparam int unsigned SLS_SLOTS  = 160;

   function automatic int unsigned sls_capacity(input int unsigned banks, input int unsigned slots);
      return banks * slots;
   endfunction
endpackage

// File: rtl/sls_phase_ring.sv
module sls_phase_ring #(
   parameter int unsigned NBANK = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_start,
   input  logic             advance,
   output logic [NBANK-1:0] bank_sel
);
   localparam logic [NBANK-1:0] HOME = NBANK'(1);

   generate
      if (NBANK < 2) begin : g_bad_nbank
         $error("sls_phase_ring: NBANK must be at least 2");
      end
   endgenerate

   logic [NBANK-1:0] phase_q;

   assign bank_sel = line_start ? HOME : phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          phase_q <= HOME;
      else if (advance)    phase_q <= {bank_sel[NBANK-2:0], bank_sel[NBANK-1]};
      else if (line_start) phase_q <= HOME;
   end

   // R8
   phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(phase_q) == 1);

   // R5
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !line_start) |=> $stable(phase_q));
endmodule

// File: rtl/sls_bank.sv
module sls_bank #(
   parameter int unsigned WIDTH = 65,
   parameter int unsigned DEPTH = 160
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_start,
   input  logic             access,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] rd_q,
   output logic             last_slot
);
   localparam logic [DEPTH-1:0] FIRST = DEPTH'(1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("sls_bank: DEPTH must be at least 2");
      end
   endgenerate

   logic [DEPTH-1:0] token_q;
   logic [DEPTH-1:0] row_en;
   logic [WIDTH-1:0] rows [DEPTH];
   logic [WIDTH-1:0] rd_mux;

   assign row_en    = line_start ? FIRST : token_q;
   assign last_slot = access & row_en[DEPTH-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          token_q <= FIRST;
      else if (access)     token_q <= {row_en[DEPTH-2:0], row_en[DEPTH-1]};
      else if (line_start) token_q <= FIRST;
   end

   always_ff @(posedge clk) begin
      for (int s = 0; s < DEPTH; s++) begin
         if (access && row_en[s]) rows[s] <= wr_data;
      end
   end

   always_comb begin
      rd_mux = '0;
      for (int s = 0; s < DEPTH; s++) begin
         rd_mux = rd_mux | (rows[s] & {WIDTH{row_en[s]}});
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_q <= '0;
      else if (access) rd_q <= rd_mux;
   end

   // R8
   token_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(token_q) == 1);

   // R5
   token_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!access && !line_start) |=> $stable(token_q));
endmodule

// File: rtl/sls_merge.sv
module sls_merge #(
   parameter int unsigned WIDTH = 65,
   parameter int unsigned NBANK = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        fire,
   input  logic                        filled,
   input  logic [NBANK-1:0]            bank_sel,
   input  logic [NBANK-1:0][WIDTH-1:0] rd_bus,
   output logic                        out_valid,
   output logic [WIDTH-1:0]            out_data
);
   logic [NBANK-1:0] pick_q;
   logic             valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pick_q  <= NBANK'(1);
         valid_q <= 1'b0;
      end else begin
         valid_q <= fire & filled;
         if (fire) pick_q <= bank_sel;
      end
   end

   always_comb begin
      out_data = '0;
      for (int b = 0; b < NBANK; b++) begin
         out_data = out_data | (rd_bus[b] & {WIDTH{pick_q[b]}});
      end
   end

   assign out_valid = valid_q;

   // R4
   pick_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($countones(pick_q) == 1));

   // R4
   valid_follows_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> !out_valid);
endmodule

// File: rtl/seq_line_store.sv
module seq_line_store
   import seq_line_pkg::*;
#(
   parameter int unsigned WIDTH = SLS_WORD_W,
   parameter int unsigned NBANK = SLS_BANKS,
   parameter int unsigned DEPTH = SLS_SLOTS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_start,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] in_data,
   output logic             out_valid,
   output logic [WIDTH-1:0] out_data
);
   localparam int unsigned CAPACITY = sls_capacity(NBANK, DEPTH);

   generate
      if (WIDTH < 1 || CAPACITY < 4) begin : g_bad_size
         $error("seq_line_store: size parameters out of range");
      end
   endgenerate

   logic [NBANK-1:0]            bank_sel;
   logic [NBANK-1:0]            bank_last;
   logic [NBANK-1:0][WIDTH-1:0] rd_bus;
   logic                        filled_q;

   sls_phase_ring #(.NBANK(NBANK)) u_ring (
      .clk(clk), .rst_n(rst_n), .line_start(line_start),
      .advance(in_valid), .bank_sel(bank_sel)
   );

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         sls_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_bank (
            .clk(clk), .rst_n(rst_n), .line_start(line_start),
            .access(in_valid & bank_sel[b]), .wr_data(in_data),
            .rd_q(rd_bus[b]), .last_slot(bank_last[b])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   filled_q <= 1'b0;
      else if (bank_last[NBANK-1])  filled_q <= 1'b1;
   end

   sls_merge #(.WIDTH(WIDTH), .NBANK(NBANK)) u_merge (
      .clk(clk), .rst_n(rst_n), .fire(in_valid), .filled(filled_q),
      .bank_sel(bank_sel), .rd_bus(rd_bus),
      .out_valid(out_valid), .out_data(out_data)
   );

   // R7
   filled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      filled_q |=> filled_q);

   // R3
   no_early_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(filled_q));

   // R8
   one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(bank_sel) == 1);
endmodule

// File: tb/sim_seq_line_store.sv
module sim_seq_line_store;
   localparam int W   = 65;
   localparam int CAP = 480;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         line_start = 1'b0;
   logic         in_valid = 1'b0;
   logic [W-1:0] in_data = '0;
   logic         out_valid;
   logic [W-1:0] out_data;

   always #5 clk = ~clk;

   seq_line_store u0 (
      .clk(clk), .rst_n(rst_n), .line_start(line_start),
      .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data)
   );

   logic [W-1:0] model [CAP];
   int           pos = 0;
   int           accepted = 0;
   logic         exp_valid = 1'b0;
   logic [W-1:0] exp_data = '0;
   string        req = "R1";
   int           checks = 0;
   int           fails = 0;
   bit           done = 1'b0;

   function automatic logic [W-1:0] rnd_word();
      return {$urandom, $urandom, 1'($urandom)};
   endfunction

   task automatic compare();
      checks++;
      if (out_valid !== exp_valid) begin
         fails++;
         $display("FAIL %s out_valid actual=%0b expected=%0b", req, out_valid, exp_valid);
      end
      if (exp_valid) begin
         checks++;
         if (out_data !== exp_data) begin
            fails++;
            $display("FAIL %s out_data actual=%h expected=%h", req, out_data, exp_data);
         end
      end
   endtask

   // one clock: check last cycle's result, drive new inputs, advance model
   task automatic step(input logic v, input logic ls, input logic [W-1:0] d);
      @(negedge clk);
      compare();
      in_valid   = v;
      line_start = ls;
      in_data    = d;
      if (ls) pos = 0;
      if (v) begin
         exp_valid  = (accepted >= CAP);
         exp_data   = model[pos];
         model[pos] = d;
         accepted++;
         pos = (pos + 1) % CAP;
      end else begin
         exp_valid = 1'b0;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      req = "R1";
      checks++;
      if (out_valid !== 1'b0) begin
         fails++;
         $display("FAIL R1 out_valid in reset actual=%0b expected=0", out_valid);
      end
      rst_n = 1'b1;
      // R3 and R5: first line with irregular gaps, output must stay low
      req = "R3";
      while (accepted < CAP) begin
         if (($urandom % 4) == 0) step(1'b0, 1'b0, rnd_word());
         else                     step(1'b1, 1'b0, rnd_word());
      end
      // R2 and R4: full second line back to back, first output is word 0
      req = "R2";
      for (int i = 0; i < CAP; i++) begin
         if (i % 5 == 0)      step(1'b1, 1'b0, {W{1'b1}});
         else if (i % 7 == 0) step(1'b1, 1'b0, '0);
         else                 step(1'b1, 1'b0, rnd_word());
      end
      // R5: long idle gaps mid-line must not disturb order
      req = "R5";
      for (int i = 0; i < 60; i++) begin
         step(1'b1, 1'b0, rnd_word());
         if (i % 10 == 3) begin
            for (int g = 0; g < 9; g++) step(1'b0, 1'b0, rnd_word());
         end
      end
      // R4: single valid then idle, output valid for exactly one cycle
      req = "R4";
      for (int i = 0; i < 30; i++) begin
         step(1'b1, 1'b0, rnd_word());
         step(1'b0, 1'b0, rnd_word());
      end
      // R6 and R7: strobe with a word after a count not divisible by 3
      req = "R6";
      for (int i = 0; i < 101; i++) step(1'b1, 1'b0, rnd_word());
      step(1'b1, 1'b1, rnd_word());
      req = "R7";
      for (int i = 0; i < 250; i++) step(1'b1, 1'b0, rnd_word());
      // R6: strobe alone, then the next word goes to position 0
      req = "R6";
      step(1'b0, 1'b1, rnd_word());
      step(1'b0, 1'b0, rnd_word());
      req = "R8";
      for (int i = 0; i < CAP + 40; i++) begin
         if (i % 11 == 10) step(1'b0, 1'b0, rnd_word());
         else              step(1'b1, 1'b0, rnd_word());
      end
      step(1'b0, 1'b0, '0);
      step(1'b0, 1'b0, '0);
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog expired in %s", req);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule